// File: doc/BRIEF.md
# Auto-Negotiation Link Timer with Completion Interrupt

This block times the link-timer intervals used by gigabit auto-negotiation in a PCS that runs either the 1000BASE-X or the SGMII standard. Each standard has its own 9-bit interval setting. A mode register chooses which setting is active. The block counts that setting in coarse units of 2^PRE_W clock cycles. With the default PRE_W of 12, one unit is 4096 cycles of the 125 MHz clock, so one unit lasts 32.768 us.

The mode register loads from a strap pin while reset is asserted. Management logic can rewrite it afterwards. A write that changes the mode restarts the timer under the new standard's setting. The negotiation state machine starts or restarts the timer with a start pulse. When the interval expires, the timer gives a one-cycle expiry pulse and halts.

The same block holds the negotiation-complete interrupt. The interrupt is set on a rising edge of the completion input, but only while it is enabled. It stays set until management clears it.

Top module: `an_link_timer`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the mode output equals the strap input (0 = 1000BASE-X, 1 = SGMII). In that state `irq`, `tmr_done` and `tmr_running` are low.
- R2: A start pulse sampled at clock edge S, with a selected setting N of 1 or more, produces `tmr_done` high for exactly the cycle after edge S + N*2^PRE_W.
- R3: A selected setting of 0 behaves like a setting of 1. The expiry pulse follows the first full prescaler period, 2^PRE_W edges after the start.
- R4: `tmr_done` is a single-cycle pulse. When it fires, `tmr_running` drops, and no further pulse occurs until the next restart.
- R5: A start pulse while the timer is running discards the interval in progress. Timing begins again from the new start edge.
- R6: With mode 0 the interval uses `tmr_val_basex`. With mode 1 it uses `tmr_val_sgmii`.
- R7: A mode write whose data differs from the current mode updates the mode on the next edge and restarts the timer exactly like a start pulse. A mode write with the current value changes nothing. Without a write, the mode holds.
- R8: A rising edge of `an_complete` while the interrupt is enabled sets `irq` on the next edge. `irq` then stays high, whatever `an_complete` does, until it is cleared.
- R9: While the interrupt is disabled, a rising edge of `an_complete` does not set `irq`. Enabling the interrupt while `an_complete` is already high does not set `irq` either.
- R10: An `irq_clr` pulse drops `irq` on the next edge. If it coincides with a qualifying rising edge, the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, nominally 125 MHz |
| rst | input | 1 | Asynchronous reset, active high |
| strap_sgmii | input | 1 | Mode loaded during reset (0 = 1000BASE-X, 1 = SGMII) |
| tmr_val_basex | input | VAL_W | Interval setting for 1000BASE-X, in prescaler units |
| tmr_val_sgmii | input | VAL_W | Interval setting for SGMII, in prescaler units |
| tmr_start | input | 1 | Start or restart the interval |
| mode_we | input | 1 | Management write strobe for the mode |
| mode_wdata | input | 1 | New mode value |
| irq_en_we | input | 1 | Management write strobe for the interrupt enable |
| irq_en_wdata | input | 1 | New interrupt-enable value |
| irq_clr | input | 1 | Clears the interrupt |
| an_complete | input | 1 | Negotiation-complete level from the arbitration logic |
| mode_sgmii | output | 1 | Current mode |
| tmr_running | output | 1 | Interval in progress |
| tmr_done | output | 1 | One-cycle expiry pulse |
| irq | output | 1 | Completion interrupt, active high |

## Verification
The bench builds the block with PRE_W = 3 and keeps VAL_W at 9. One unit therefore lasts 8 cycles. This brings expiry timing, zero-setting handling, restarts in mid-interval and mode-change restarts within a few hundred cycles, with the same counter structure as the default build. The scoreboard predicts each expiry edge as start edge + N*8 and compares it against every observed pulse. Unexpected pulses and missing pulses are both reported.

// File: rtl/an_tmr_pkg.sv
package an_tmr_pkg;

    typedef struct packed {
        logic en;
        logic irq;
        logic cmpl;
    } irq_state_t;

    typedef struct packed {
        logic sgmii;
    } mode_state_t;

endpackage

// File: rtl/an_tmr_prescale.sv
module an_tmr_prescale #(
    parameter int PRE_W = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic run,
    output logic tick
);
    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_state_t;

    pre_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (clear) begin
            state_d.cnt = '0;
        end else if (run) begin
            state_d.cnt = state_q.cnt + 1'b1;
        end
        tick = run && !clear && (state_q.cnt == {PRE_W{1'b1}});
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end
endmodule

// File: rtl/an_tmr_count.sv
module an_tmr_count #(
    parameter int VAL_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             tick,
    input  logic [VAL_W-1:0] limit,
    output logic             running,
    output logic             done
);
    localparam int NXT_W = VAL_W + 1;

    typedef struct packed {
        logic [VAL_W-1:0] cnt;
        logic             run;
        logic             done;
    } cnt_state_t;

    cnt_state_t       state_d, state_q;
    logic [NXT_W-1:0] nxt;

    always_comb begin
        state_d      = state_q;
        state_d.done = 1'b0;
        nxt          = {1'b0, state_q.cnt} + 1'b1;
        if (restart) begin
            state_d.cnt = '0;
            state_d.run = 1'b1;
        end else if (tick && state_q.run) begin
            state_d.cnt = nxt[VAL_W-1:0];
            if (nxt >= {1'b0, limit}) begin
                state_d.run  = 1'b0;
                state_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign running = state_q.run;
    assign done    = state_q.done;
endmodule

// File: rtl/an_irq_ctrl.sv
module an_irq_ctrl
    import an_tmr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en_we,
    input  logic en_wdata,
    input  logic clr,
    input  logic cmpl,
    output logic en,
    output logic irq
);
    irq_state_t state_d, state_q;
    logic       rise;

    always_comb begin
        state_d      = state_q;
        state_d.cmpl = cmpl;
        rise         = cmpl && !state_q.cmpl;
        if (en_we) begin
            state_d.en = en_wdata;
        end
        if (clr) begin
            state_d.irq = 1'b0;
        end else if (rise && state_q.en) begin
            state_d.irq = 1'b1;
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign en  = state_q.en;
    assign irq = state_q.irq;
endmodule

// File: rtl/an_link_timer.sv
module an_link_timer
    import an_tmr_pkg::*;
#(
    parameter int VAL_W = 9,
    parameter int PRE_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             strap_sgmii,
    input  logic [VAL_W-1:0] tmr_val_basex,
    input  logic [VAL_W-1:0] tmr_val_sgmii,
    input  logic             tmr_start,
    input  logic             mode_we,
    input  logic             mode_wdata,
    input  logic             irq_en_we,
    input  logic             irq_en_wdata,
    input  logic             irq_clr,
    input  logic             an_complete,
    output logic             mode_sgmii,
    output logic             tmr_running,
    output logic             tmr_done,
    output logic             irq
);
    mode_state_t      mode_d, mode_q;
    logic             mode_chg;
    logic             restart;
    logic             tick;
    logic [VAL_W-1:0] limit;
    logic             irq_en_w;

    always_comb begin
        mode_d   = mode_q;
        mode_chg = mode_we && (mode_wdata != mode_q.sgmii);
        if (mode_chg) begin
            mode_d.sgmii = mode_wdata;
        end
        restart = tmr_start || mode_chg;
        limit   = mode_q.sgmii ? tmr_val_sgmii : tmr_val_basex;
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            mode_q.sgmii <= strap_sgmii;
        end else begin
            mode_q <= mode_d;
        end
    end

    an_tmr_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk   (clk),
        .rst   (rst),
        .clear (restart),
        .run   (tmr_running),
        .tick  (tick)
    );

    an_tmr_count #(.VAL_W(VAL_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .tick    (tick),
        .limit   (limit),
        .running (tmr_running),
        .done    (tmr_done)
    );

    an_irq_ctrl u_irq (
        .clk      (clk),
        .rst      (rst),
        .en_we    (irq_en_we),
        .en_wdata (irq_en_wdata),
        .clr      (irq_clr),
        .cmpl     (an_complete),
        .en       (irq_en_w),
        .irq      (irq)
    );

    assign mode_sgmii = mode_q.sgmii;
endmodule

// File: rtl/an_link_timer_chk.sv
module an_link_timer_chk (
    input logic clk,
    input logic rst,
    input logic tmr_start,
    input logic mode_we,
    input logic mode_wdata,
    input logic mode_sgmii,
    input logic an_complete,
    input logic irq_en,
    input logic irq_clr,
    input logic irq,
    input logic tmr_running,
    input logic tmr_done
);
    AST_RESTART_RUNS: assert property (@(posedge clk) disable iff (rst)
        tmr_start |=> tmr_running && !tmr_done); // R5
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        tmr_done |=> !tmr_done); // R4
    AST_DONE_HALTS: assert property (@(posedge clk) disable iff (rst)
        tmr_done |-> !tmr_running); // R4
    AST_MODE_KEEP: assert property (@(posedge clk) disable iff (rst)
        !mode_we |=> $stable(mode_sgmii)); // R7
    AST_MODE_RESTART: assert property (@(posedge clk) disable iff (rst)
        (mode_we && (mode_wdata != mode_sgmii)) |=> tmr_running && (mode_sgmii != $past(mode_sgmii))); // R7
    AST_IRQ_SET: assert property (@(posedge clk) disable iff (rst)
        ($rose(an_complete) && irq_en && !irq_clr) |=> irq); // R8
    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (irq && !irq_clr) |=> irq); // R8
    AST_IRQ_MASK: assert property (@(posedge clk) disable iff (rst)
        (!irq && !irq_en) |=> !irq); // R9
    AST_IRQ_CLR: assert property (@(posedge clk) disable iff (rst)
        irq_clr |=> !irq); // R10
endmodule

bind an_link_timer an_link_timer_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .tmr_start   (tmr_start),
    .mode_we     (mode_we),
    .mode_wdata  (mode_wdata),
    .mode_sgmii  (mode_sgmii),
    .an_complete (an_complete),
    .irq_en      (irq_en_w),
    .irq_clr     (irq_clr),
    .irq         (irq),
    .tmr_running (tmr_running),
    .tmr_done    (tmr_done)
);

// File: tb/an_link_timer_tb.sv
`timescale 1ns/1ps
module an_link_timer_tb;
    localparam int VAL_W = 9;
    localparam int PRE_W = 3;
    localparam int UNIT  = 1 << PRE_W;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             strap_sgmii = 1'b1;
    logic [VAL_W-1:0] tmr_val_basex = 9'd5;
    logic [VAL_W-1:0] tmr_val_sgmii = 9'd3;
    logic             tmr_start = 1'b0;
    logic             mode_we = 1'b0;
    logic             mode_wdata = 1'b0;
    logic             irq_en_we = 1'b0;
    logic             irq_en_wdata = 1'b0;
    logic             irq_clr = 1'b0;
    logic             an_complete = 1'b0;
    logic             mode_sgmii, tmr_running, tmr_done, irq;

    int unsigned cyc = 0;
    int          total = 0;
    int          bad = 0;
    bit          finished = 1'b0;
    int unsigned exp_q[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    an_link_timer #(.VAL_W(VAL_W), .PRE_W(PRE_W)) u_dut (
        .clk(clk), .rst(rst), .strap_sgmii(strap_sgmii),
        .tmr_val_basex(tmr_val_basex), .tmr_val_sgmii(tmr_val_sgmii),
        .tmr_start(tmr_start), .mode_we(mode_we), .mode_wdata(mode_wdata),
        .irq_en_we(irq_en_we), .irq_en_wdata(irq_en_wdata), .irq_clr(irq_clr),
        .an_complete(an_complete), .mode_sgmii(mode_sgmii),
        .tmr_running(tmr_running), .tmr_done(tmr_done), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // driver: a restart supersedes any pending expiry
    task automatic expect_restart(input int n);
        int units;
        units = (n == 0) ? 1 : n;
        exp_q.delete();
        exp_q.push_back(cyc + 1 + units * UNIT);
    endtask

    task automatic start_tmr(input int n);
        tmr_start = 1'b1;
        expect_restart(n);
        @(negedge clk);
        tmr_start = 1'b0;
    endtask

    // monitor: compares each observed expiry against the scoreboard
    always @(negedge clk) begin
        if (!rst && tmr_done) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R4 unexpected expiry", cyc, 0);
            end else begin
                int unsigned e;
                e = exp_q.pop_front();
                chk(cyc == e, "R2 expiry cycle", cyc, e);
            end
        end
    end

    initial begin
        #(4 * 200000);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        wait_cyc(3);
        chk(mode_sgmii == 1'b1, "R1 mode during reset", mode_sgmii, 1);
        rst = 1'b0;
        @(negedge clk);
        chk(mode_sgmii == 1'b1, "R1 mode from strap", mode_sgmii, 1);
        chk(irq == 1'b0, "R1 irq idle", irq, 0);
        chk(tmr_running == 1'b0, "R1 timer idle", tmr_running, 0);
        chk(tmr_done == 1'b0, "R1 no expiry", tmr_done, 0);

        // R2 R6: SGMII setting 3
        start_tmr(3);
        chk(tmr_running == 1'b1, "R2 running after start", tmr_running, 1);
        wait_cyc(40);
        chk(exp_q.size() == 0, "R6 sgmii expiry seen", exp_q.size(), 0);
        chk(tmr_running == 1'b0, "R4 halted after expiry", tmr_running, 0);

        // R3: zero setting
        tmr_val_sgmii = 9'd0;
        start_tmr(0);
        wait_cyc(20);
        chk(exp_q.size() == 0, "R3 zero setting expiry", exp_q.size(), 0);
        tmr_val_sgmii = 9'd3;

        // R5: restart in mid-interval
        start_tmr(3);
        wait_cyc(10);
        start_tmr(3);
        wait_cyc(40);
        chk(exp_q.size() == 0, "R5 restart expiry", exp_q.size(), 0);

        // R7 R6: mode change restarts using 1000BASE-X setting 5
        mode_we = 1'b1;
        mode_wdata = 1'b0;
        expect_restart(5);
        @(negedge clk);
        mode_we = 1'b0;
        chk(mode_sgmii == 1'b0, "R7 mode written", mode_sgmii, 0);
        chk(tmr_running == 1'b1, "R7 restart on change", tmr_running, 1);
        wait_cyc(10);
        mode_we = 1'b1;
        @(negedge clk);
        mode_we = 1'b0;
        chk(mode_sgmii == 1'b0, "R7 same-value write", mode_sgmii, 0);
        wait_cyc(40);
        chk(exp_q.size() == 0, "R6 basex expiry", exp_q.size(), 0);

        // R9: disabled interrupt ignores the rising edge
        an_complete = 1'b1;
        @(negedge clk);
        chk(irq == 1'b0, "R9 masked edge", irq, 0);
        irq_en_we = 1'b1;
        irq_en_wdata = 1'b1;
        @(negedge clk);
        irq_en_we = 1'b0;
        wait_cyc(2);
        chk(irq == 1'b0, "R9 enable on high level", irq, 0);
        an_complete = 1'b0;
        wait_cyc(2);

        // R8: set and hold
        an_complete = 1'b1;
        @(negedge clk);
        chk(irq == 1'b1, "R8 set on edge", irq, 1);
        an_complete = 1'b0;
        wait_cyc(5);
        chk(irq == 1'b1, "R8 held", irq, 1);

        // R10: clear, then clear beats set
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        chk(irq == 1'b0, "R10 cleared", irq, 0);
        an_complete = 1'b1;
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        chk(irq == 1'b0, "R10 clear priority", irq, 0);
        wait_cyc(2);
        chk(irq == 1'b0, "R10 no late set", irq, 0);
        an_complete = 1'b0;

        // R1: second reset with strap low
        strap_sgmii = 1'b0;
        mode_we = 1'b1;
        mode_wdata = 1'b1;
        @(negedge clk);
        mode_we = 1'b0;
        exp_q.delete();
        rst = 1'b1;
        wait_cyc(2);
        rst = 1'b0;
        @(negedge clk);
        chk(mode_sgmii == 1'b0, "R1 mode from strap low", mode_sgmii, 0);
        chk(tmr_running == 1'b0, "R1 timer idle after reset", tmr_running, 0);
        chk(irq == 1'b0, "R1 irq idle after reset", irq, 0);
        wait_cyc(60);
        chk(exp_q.size() == 0, "R4 no pending expiry", exp_q.size(), 0);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule